// File: doc/BRIEF.md
# Live-Biased Load Dependency Predictor

This block tells a speculative thread whether a load is likely to pick up its value from a store in an older, less speculative thread. It answers "live", meaning a communicating store is expected, or "dead", meaning no such store is expected. A table of small saturating counters holds the history. The table is indexed by the low bits of the load's instruction address, because the same load/store instruction pair tends to communicate across many different data addresses.

A counter says dead only when it is saturated at all ones. Each load that did not communicate adds one. Each load that did communicate drops the counter to zero. A dead prediction is therefore earned slowly and lost at once. This bias exists because a wrong dead call costs a whole thread restart, while a wrong live call only costs a value prediction.

When a snooped store breaks a dead prediction, only the data (effective) address is known. The violation tracker saves that address and arms itself. After the restart, it compares the effective address of every load against the saved one. The first load that matches supplies its instruction address, and the table entry at that index is cleared.

The tracker is a two-state machine:
- IDLE → ARMED on a violation (RECORD).
- ARMED → ARMED on a further violation, which overwrites the saved address (REARM).
- ARMED → IDLE on the first matching load when no violation arrives in the same cycle (HIT).
- Every other case holds the current state.

Top module: `dep_pred`

## Requirements
- R1: After reset every table entry is zero, so every lookup answers live (`lk_dead`=0), and `trk_armed` is 0.
- R2: The table has 2^IDX_W entries of CNT_W bits. The entry for an address is selected by its bits [IDX_W-1:0]; other bits play no part. `lk_dead` is 1 exactly when the selected entry is all ones. It is a combinational read of the current table contents.
- R3: A training update with `tr_comm`=1 writes zero to the selected entry at the next clock edge.
- R4: A training update with `tr_comm`=0 increments the selected entry, saturating at all ones. From zero, the 63rd consecutive non-communicating update (CNT_W=6) is the first to make the lookup answer dead; further updates keep it dead.
- R5: A lookup and a training update to the same index in one cycle return the value held before the update. The updated value is visible from the next cycle.
- R6: `vio_valid` saves `vio_ea` and sets `trk_armed` at the next edge. A violation while armed replaces the saved address.
- R7: While armed, a load (`ld_valid`) whose `ld_ea` equals the saved address clears the entry selected by `ld_pc`. It also drops `trk_armed` at the next edge unless a violation arrives in the same cycle. A load with any other effective address changes nothing.
- R8: While not armed, loads change neither the table nor `trk_armed`.
- R9: When a tracker clear and a training update hit the same index in one cycle, the entry ends at zero.
- R10: When a violation and a matching load arrive in one cycle, the clear uses the previously saved address, and the tracker stays armed holding the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | Instruction address of the load being looked up |
| lk_dead | output | 1 | 1 = predicted dead, 0 = predicted live |
| tr_valid | input | 1 | Training update strobe |
| tr_pc | input | PC_W | Instruction address of the trained load |
| tr_comm | input | 1 | 1 = the load communicated with a store |
| vio_valid | input | 1 | Dead-prediction violation strobe |
| vio_ea | input | PC_W | Effective address that caused the violation |
| ld_valid | input | 1 | A load executed after a restart |
| ld_pc | input | PC_W | That load's instruction address |
| ld_ea | input | PC_W | That load's effective address |
| trk_armed | output | 1 | Violation tracker holds a pending address |

## Verification
The bench fills one counter with exactly 62 and then 63 non-communicating updates, to catch an off-by-one saturation threshold. It then pushes the counter past the top, which exposes a design that wraps to zero and silently returns to live.

It issues a lookup and a clear to the same index in one cycle, which catches a design that bypasses the write into the read. It uses two addresses that share low bits, which catches hashing on the wrong bits.

On the tracker side, it sends non-matching loads, loads while idle, and a violation arriving together with a matching load. A design that compares against the new address, clears on a mismatch, or disarms on a rearm shows up as a wrong live/dead answer or a wrong `trk_armed`. Random traffic over a few hot indices and four effective addresses then mixes all of these against a reference model.

// File: rtl/dp_pkg.sv
package dp_pkg;
    typedef enum logic [0:0] {
        TRK_IDLE  = 1'b0,
        TRK_ARMED = 1'b1
    } trk_state_e;
endpackage

// File: rtl/dp_table.sv
module dp_table #(
    parameter int IDX_W = 6,
    parameter int CNT_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic                          rd_dead,
    input  logic                          tr_en,
    input  logic [IDX_W-1:0]              tr_idx,
    input  logic                          tr_comm,
    input  logic                          clr_en,
    input  logic [IDX_W-1:0]              clr_idx,
    output logic [(1<<IDX_W)*CNT_W-1:0]   cnt_flat
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic hit_clr, hit_tr;
        assign hit_clr = clr_en && (clr_idx == IDX_W'(i));
        assign hit_tr  = tr_en  && (tr_idx  == IDX_W'(i));

        // A tracker clear overrides a training update on the same entry.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[i] <= '0;
            end else if (hit_clr) begin
                cnt_q[i] <= '0;
            end else if (hit_tr) begin
                if (tr_comm)
                    cnt_q[i] <= '0;
                else if (cnt_q[i] != CNT_MAX)
                    cnt_q[i] <= cnt_q[i] + 1'b1;
            end
        end

        assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q[i];
    end

    // Combinational read: same-cycle writes become visible only after the edge.
    assign rd_dead = (cnt_q[rd_idx] == CNT_MAX);
endmodule

// File: rtl/dp_tracker.sv
module dp_tracker
    import dp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vio_valid,
    input  logic [PC_W-1:0]  vio_ea,
    input  logic             ld_valid,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [PC_W-1:0]  ld_ea,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx,
    output logic             armed,
    output logic [PC_W-1:0]  saved_ea
);
    trk_state_e state_q, state_d;
    logic       ea_match;

    assign ea_match = ld_valid && (ld_ea == saved_ea);

    // State and saved-address register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= TRK_IDLE;
            saved_ea <= '0;
        end else begin
            state_q <= state_d;
            if (vio_valid)
                saved_ea <= vio_ea;
        end
    end

    // Next state: RECORD, REARM, HIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE:  if (vio_valid) state_d = TRK_ARMED;
            TRK_ARMED: begin
                if (vio_valid)     state_d = TRK_ARMED;
                else if (ea_match) state_d = TRK_IDLE;
            end
            default:   state_d = TRK_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        clr_en  = 1'b0;
        clr_idx = ld_idx;
        armed   = 1'b0;
        unique case (state_q)
            TRK_IDLE:  ;
            TRK_ARMED: begin
                armed  = 1'b1;
                clr_en = ea_match;
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/dep_pred.sv
module dep_pred #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int CNT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_dead,
    input  logic            tr_valid,
    input  logic [PC_W-1:0] tr_pc,
    input  logic            tr_comm,
    input  logic            vio_valid,
    input  logic [PC_W-1:0] vio_ea,
    input  logic            ld_valid,
    input  logic [PC_W-1:0] ld_pc,
    input  logic [PC_W-1:0] ld_ea,
    output logic            trk_armed
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0]       clr_idx;
    logic                   clr_en;
    logic [PC_W-1:0]        saved_ea_w;
    logic [DEPTH*CNT_W-1:0] cnt_flat_w;
    logic                   unused_hi;

    // Only the low address bits select an entry.
    assign unused_hi = ^{lk_pc[PC_W-1:IDX_W], tr_pc[PC_W-1:IDX_W], ld_pc[PC_W-1:IDX_W]};

    dp_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_pc[IDX_W-1:0]),
        .rd_dead  (lk_dead),
        .tr_en    (tr_valid),
        .tr_idx   (tr_pc[IDX_W-1:0]),
        .tr_comm  (tr_comm),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .cnt_flat (cnt_flat_w)
    );

    dp_tracker #(.PC_W(PC_W), .IDX_W(IDX_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .vio_valid (vio_valid),
        .vio_ea    (vio_ea),
        .ld_valid  (ld_valid),
        .ld_idx    (ld_pc[IDX_W-1:0]),
        .ld_ea     (ld_ea),
        .clr_en    (clr_en),
        .clr_idx   (clr_idx),
        .armed     (trk_armed),
        .saved_ea  (saved_ea_w)
    );
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int CNT_W = 6
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          tr_valid,
    input logic [PC_W-1:0]               tr_pc,
    input logic                          tr_comm,
    input logic                          vio_valid,
    input logic [PC_W-1:0]               vio_ea,
    input logic                          ld_valid,
    input logic [PC_W-1:0]               ld_pc,
    input logic [PC_W-1:0]               ld_ea,
    input logic                          armed,
    input logic [PC_W-1:0]               saved_ea,
    input logic [(1<<IDX_W)*CNT_W-1:0]   cnt_flat
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [IDX_W-1:0] tr_idx, prev_tr_idx;
    logic [CNT_W-1:0] tr_ent, prev_ent;
    logic             clr_same;

    assign tr_idx   = tr_pc[IDX_W-1:0];
    assign tr_ent   = cnt_flat[int'(tr_idx)*CNT_W +: CNT_W];
    assign prev_ent = cnt_flat[int'(prev_tr_idx)*CNT_W +: CNT_W];
    assign clr_same = armed && ld_valid && (ld_ea == saved_ea) && (ld_pc[IDX_W-1:0] == tr_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_tr_idx <= '0;
        else        prev_tr_idx <= tr_idx;
    end

    // R3: communicated load zeroes its entry
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid && tr_comm |=> prev_ent == '0);

    // R4: a saturated entry stays saturated on a further increment
    p_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid && !tr_comm && tr_ent == CNT_MAX && !clr_same |=> prev_ent == CNT_MAX);

    // R6: violation arms the tracker and saves the address
    p_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vio_valid |=> armed && saved_ea == $past(vio_ea));

    // R7: a matching load disarms the tracker
    p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ld_valid && ld_ea == saved_ea && !vio_valid |=> !armed);

    // R8: nothing but a violation arms the idle tracker
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed && !vio_valid |=> !armed);
endmodule

bind dep_pred dp_checker #(.PC_W(PC_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tr_valid  (tr_valid),
    .tr_pc     (tr_pc),
    .tr_comm   (tr_comm),
    .vio_valid (vio_valid),
    .vio_ea    (vio_ea),
    .ld_valid  (ld_valid),
    .ld_pc     (ld_pc),
    .ld_ea     (ld_ea),
    .armed     (trk_armed),
    .saved_ea  (saved_ea_w),
    .cnt_flat  (cnt_flat_w)
);

// File: tb/sim_dep_pred.sv
module sim_dep_pred;
    localparam int PC_W  = 32;
    localparam int IDX_W = 6;
    localparam int CNT_W = 6;
    localparam int DEPTH = 1 << IDX_W;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            lk_dead;
    logic            tr_valid = 1'b0;
    logic [PC_W-1:0] tr_pc = '0;
    logic            tr_comm = 1'b0;
    logic            vio_valid = 1'b0;
    logic [PC_W-1:0] vio_ea = '0;
    logic            ld_valid = 1'b0;
    logic [PC_W-1:0] ld_pc = '0;
    logic [PC_W-1:0] ld_ea = '0;
    logic            trk_armed;

    always #5 clk = ~clk;

    dep_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_dead(lk_dead),
        .tr_valid(tr_valid), .tr_pc(tr_pc), .tr_comm(tr_comm),
        .vio_valid(vio_valid), .vio_ea(vio_ea),
        .ld_valid(ld_valid), .ld_pc(ld_pc), .ld_ea(ld_ea),
        .trk_armed(trk_armed)
    );

    int            n_chk = 0;
    int            n_fail = 0;
    int            m_cnt [DEPTH];
    bit            m_armed = 0;
    logic [PC_W-1:0] m_ea = '0;

    function automatic int ix(logic [PC_W-1:0] a);
        return int'(a[IDX_W-1:0]);
    endfunction

    function automatic bit exp_dead(logic [PC_W-1:0] a);
        return m_cnt[ix(a)] == CMAX;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, check lookup before the edge, update model, check tracker after it.
    task automatic step(string tag, logic [PC_W-1:0] lpc, bit trv, logic [PC_W-1:0] tpc, bit tc,
                        bit vv, logic [PC_W-1:0] vea, bit lv, logic [PC_W-1:0] lp, logic [PC_W-1:0] lea);
        bit clr;
        @(negedge clk);
        lk_pc = lpc; tr_valid = trv; tr_pc = tpc; tr_comm = tc;
        vio_valid = vv; vio_ea = vea; ld_valid = lv; ld_pc = lp; ld_ea = lea;
        #1;
        chk(tag, "lk_dead", int'(lk_dead), int'(exp_dead(lpc)));
        @(posedge clk);
        clr = m_armed && lv && (lea == m_ea);
        if (trv) begin
            if (tc) m_cnt[ix(tpc)] = 0;
            else if (m_cnt[ix(tpc)] < CMAX) m_cnt[ix(tpc)]++;
        end
        if (clr) m_cnt[ix(lp)] = 0;
        if (vv) begin m_armed = 1; m_ea = vea; end
        else if (clr) m_armed = 0;
        #1;
        chk(tag, "trk_armed", int'(trk_armed), int'(m_armed));
    endtask

    task automatic look(string tag, logic [PC_W-1:0] lpc);
        step(tag, lpc, 0, '0, 0, 0, '0, 0, '0, '0);
    endtask

    task automatic train(string tag, logic [PC_W-1:0] pc, bit c, int n);
        for (int k = 0; k < n; k++) step(tag, pc, 1, pc, c, 0, '0, 0, '0, '0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_cnt[i] = 0;
        void'($urandom(32'd4242));
        #23 rst_n = 1'b1;

        // R1: reset state
        look("R1", 32'h0000_0000);
        look("R1", 32'h0000_003F);
        look("R1", 32'hFFFF_FF15);

        // R4: threshold of 63 increments, then saturation
        train("R4", 32'h0000_0105, 0, 62);
        look("R4", 32'h0000_0105);
        train("R4", 32'h0000_0105, 0, 1);
        look("R4", 32'h0000_0105);
        train("R4", 32'h0000_0105, 0, 3);
        // R2: aliasing through low bits only
        look("R2", 32'hABCD_0005);
        look("R2", 32'h0000_0006);

        // R5 + R3: lookup during a clearing update sees the old value
        step("R5", 32'h0000_0005, 1, 32'h7000_0005, 1, 0, '0, 0, '0, '0);
        look("R3", 32'h0000_0005);

        // Build dead entries at 9 and 12
        train("R4", 32'h0000_0009, 0, 63);
        train("R4", 32'h0000_000C, 0, 63);
        look("R2", 32'h0000_0009);

        // R8: loads while idle do nothing
        step("R8", 32'h0000_0009, 0, '0, 0, 0, '0, 1, 32'h0000_0009, 32'h0000_0000);
        look("R8", 32'h0000_0009);

        // R6: violation arms
        step("R6", 32'h0000_0009, 0, '0, 0, 1, 32'h0000_1ABC, 0, '0, '0);
        // R7: mismatching load changes nothing
        step("R7", 32'h0000_0009, 0, '0, 0, 0, '0, 1, 32'h0000_0009, 32'h0000_1ABD);
        look("R7", 32'h0000_0009);
        // R6: overwrite with a new address, old one no longer matches
        step("R6", 32'h0000_0009, 0, '0, 0, 1, 32'h0000_2000, 0, '0, '0);
        step("R6", 32'h0000_0009, 0, '0, 0, 0, '0, 1, 32'h0000_0009, 32'h0000_1ABC);
        look("R6", 32'h0000_0009);
        // R7: matching load clears entry 9 and disarms
        step("R7", 32'h0000_0009, 0, '0, 0, 0, '0, 1, 32'h5555_0009, 32'h0000_2000);
        look("R7", 32'h0000_0009);
        look("R7", 32'h0000_000C);

        // R10: violation with a matching load in the same cycle
        step("R10", 32'h0000_000C, 0, '0, 0, 1, 32'h0000_3000, 0, '0, '0);
        step("R10", 32'h0000_000C, 0, '0, 0, 1, 32'h0000_4000, 1, 32'h0000_000C, 32'h0000_3000);
        look("R10", 32'h0000_000C);

        // R9: clear and increment on the same index
        train("R9", 32'h0000_0011, 0, 63);
        step("R9", 32'h0000_0011, 1, 32'h0000_0011, 0, 0, '0, 1, 32'h0000_0011, 32'h0000_4000);
        look("R9", 32'h0000_0011);

        // Random traffic over hot indices and a few effective addresses
        for (int n = 0; n < 3000; n++) begin
            logic [PC_W-1:0] eas [4];
            logic [PC_W-1:0] a_lk, a_tr, a_ld;
            eas[0] = 32'h100; eas[1] = 32'h200; eas[2] = 32'h300; eas[3] = 32'h400;
            a_lk = {$urandom % 16, 2'b0, 4'($urandom % 4)} | 32'h20;
            a_tr = {$urandom % 16, 2'b0, 4'($urandom % 4)} | 32'h20;
            a_ld = {$urandom % 16, 2'b0, 4'($urandom % 4)} | 32'h20;
            step("R2", a_lk, ($urandom % 4) != 0, a_tr, ($urandom % 40) == 0,
                 ($urandom % 30) == 0, eas[$urandom % 4],
                 ($urandom % 3) == 0, a_ld, eas[$urandom % 4]);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule